// File: doc/BRIEF.md
# Phase Accumulator with Clear Controls

This block is the phase generator of a numerically controlled oscillator. On every sample clock it adds a 32-bit frequency tuning word to a running phase value, wrapping modulo 2^32, and presents the result as a registered phase word for a later angle-to-amplitude stage.

Two control inputs can force the phase to zero. A level-sensitive hold keeps the accumulator at zero for as long as it is asserted. An armed auto-zero clears the accumulator once whenever an update strobe or a profile-change strobe arrives. The block also drives a select flag that tells the amplitude stage to produce sine instead of cosine. That flag can be high only in the single-tone operating mode.

Top module: `phase_accum_top`

## Requirements
- R1: With no clear active, each clock adds `tune_word` to the accumulator modulo 2^32, so the sum wraps past 0xFFFFFFFF.
- R2: While `zero_hold` is 1 the accumulator is zero. This hold overrides the auto-zero and normal accumulation.
- R3: When `auto_zero_arm` is 1, an `upd_strobe` or a `prof_strobe` zeroes the accumulator for that clock. When `auto_zero_arm` is 0, both strobes have no effect on the phase.
- R4: If an auto-zero event and a new tuning word arrive in the same clock, the accumulator is zero after that clock. Accumulation resumes with the new word on the following clock.
- R5: `phase_word` equals the accumulator value one clock earlier, so it carries exactly one register of latency.
- R6: `sine_sel` is 1 only when `op_mode` is 2'b01 (single tone) and `sine_req` is 1. For any other mode it is 0 (cosine). It carries one clock of latency.
- R7: After reset, `phase_word` is 0 and `sine_sel` is 0, which selects cosine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tune_word | input | 32 | Frequency tuning word |
| upd_strobe | input | 1 | Update event, one clock wide |
| prof_strobe | input | 1 | Profile-change event, one clock wide |
| auto_zero_arm | input | 1 | Arms the event-triggered clear |
| zero_hold | input | 1 | Static clear, active while high |
| op_mode | input | 2 | Operating mode; 2'b01 is single tone |
| sine_req | input | 1 | Requests sine output in single-tone mode |
| phase_word | output | 32 | Registered phase word |
| sine_sel | output | 1 | 1 selects sine, 0 selects cosine |

## Verification
Inputs sampled at clock edge k update the accumulator at that edge. The phase word shows that accumulator update one edge later, at edge k+1. The select flag follows the mode inputs of edge k after that same edge, so it has one clock of latency. The driver applies each stimulus on a falling edge. At that point it pushes the phase the model held before the update, together with the select value the model derives. The monitor pops and compares one entry shortly after every rising edge, so each result is checked in the exact cycle it is due.

// File: rtl/phase_acc_pkg.sv
package phase_acc_pkg;
  localparam int unsigned PHASE_W = 32;

  typedef enum logic [1:0] {
    MODE_QUAD   = 2'b00,
    MODE_TONE   = 2'b01,
    MODE_INTP_A = 2'b10,
    MODE_INTP_B = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic hold;
    logic event_clr;
  } clr_req_t;
endpackage

// File: rtl/rst_release.sv
module rst_release #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/clear_ctrl.sv
module clear_ctrl
  import phase_acc_pkg::*;
(
  input  logic     upd_i,
  input  logic     prof_i,
  input  logic     arm_i,
  input  logic     hold_i,
  output clr_req_t req_o
);
  always_comb begin
    req_o.hold      = hold_i;
    req_o.event_clr = arm_i && (upd_i || prof_i);
  end
endmodule

// File: rtl/phase_adder.sv
module phase_adder
  import phase_acc_pkg::*;
#(
  parameter int unsigned W = PHASE_W
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [W-1:0] ftw_i,
  input  clr_req_t     req_i,
  output logic [W-1:0] acc_o
);
  logic [W-1:0] acc_q, acc_d;
  logic         acc_en;

  assign acc_en = 1'b1;

  always_comb begin
    if (req_i.hold)           acc_d = '0;
    else if (req_i.event_clr) acc_d = '0;
    else                      acc_d = acc_q + ftw_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    req_i.hold |=> (acc_q == '0));
  p_event_zero_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    req_i.event_clr |=> (acc_q == '0));
  p_wrap_add_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (!req_i.hold && !req_i.event_clr) |=> (acc_q == $past(acc_q) + $past(ftw_i)));
  p_resume_new_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (!req_i.hold && !req_i.event_clr && $past(req_i.event_clr)) |=> (acc_q == $past(ftw_i)));
endmodule

// File: rtl/out_stage.sv
module out_stage
  import phase_acc_pkg::*;
#(
  parameter int unsigned W = PHASE_W
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [W-1:0] acc_i,
  input  logic [1:0]   mode_i,
  input  logic         sine_req_i,
  output logic [W-1:0] phase_o,
  output logic         sine_o
);
  logic [W-1:0] phase_q, phase_d;
  logic         sine_q, sine_d;

  always_comb begin
    phase_d = acc_i;
    sine_d  = (mode_i == MODE_TONE) && sine_req_i;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q <= '0;
      sine_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sine_q  <= sine_d;
    end
  end

  assign phase_o = phase_q;
  assign sine_o  = sine_q;

  p_phase_lag_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> (phase_q == $past(acc_i)));
  p_cos_outside_tone_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (mode_i != MODE_TONE) |=> !sine_q);
  p_cos_without_req_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    !sine_req_i |=> !sine_q);
endmodule

// File: rtl/phase_accum_top.sv
module phase_accum_top
  import phase_acc_pkg::*;
#(
  parameter int unsigned W         = PHASE_W,
  parameter int unsigned RST_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tune_word,
  input  logic         upd_strobe,
  input  logic         prof_strobe,
  input  logic         auto_zero_arm,
  input  logic         zero_hold,
  input  logic [1:0]   op_mode,
  input  logic         sine_req,
  output logic [W-1:0] phase_word,
  output logic         sine_sel
);
  logic         rst_sn;
  clr_req_t     req;
  logic [W-1:0] acc;

  rst_release #(.STAGES(RST_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  clear_ctrl u_clr (
    .upd_i(upd_strobe), .prof_i(prof_strobe), .arm_i(auto_zero_arm),
    .hold_i(zero_hold), .req_o(req)
  );

  phase_adder #(.W(W)) u_add (
    .clk(clk), .rst_sn(rst_sn), .ftw_i(tune_word), .req_i(req), .acc_o(acc)
  );

  out_stage #(.W(W)) u_out (
    .clk(clk), .rst_sn(rst_sn), .acc_i(acc), .mode_i(op_mode),
    .sine_req_i(sine_req), .phase_o(phase_word), .sine_o(sine_sel)
  );

  p_reset_cos_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(rst_sn) |-> (phase_word == '0 && !sine_sel));
endmodule

// File: tb/phase_accum_top_test.sv
module phase_accum_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] tune_word;
  logic        upd_strobe, prof_strobe, auto_zero_arm, zero_hold, sine_req;
  logic [1:0]  op_mode;
  logic [31:0] phase_word;
  logic        sine_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] mdl_acc;
  logic [31:0] exp_ph_q[$];
  logic        exp_sel_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_accum_top uut (
    .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .upd_strobe(upd_strobe),
    .prof_strobe(prof_strobe), .auto_zero_arm(auto_zero_arm), .zero_hold(zero_hold),
    .op_mode(op_mode), .sine_req(sine_req), .phase_word(phase_word), .sine_sel(sine_sel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ftw, input logic upd, input logic prof,
                       input logic arm, input logic hold, input logic [1:0] mode,
                       input logic sreq, input string tag);
    @(negedge clk);
    tune_word = ftw; upd_strobe = upd; prof_strobe = prof;
    auto_zero_arm = arm; zero_hold = hold; op_mode = mode; sine_req = sreq;
    exp_ph_q.push_back(mdl_acc);
    exp_sel_q.push_back(mode == 2'b01 && sreq);
    tag_q.push_back(tag);
    if (hold)                    mdl_acc = '0;
    else if (arm && (upd || prof)) mdl_acc = '0;
    else                         mdl_acc = mdl_acc + ftw;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_ph_q.size() > 0) begin
      string t;
      t = tag_q.pop_front();
      check({t, " phase"}, phase_word, exp_ph_q.pop_front());
      check({t, " select"}, {31'd0, sine_sel}, {31'd0, exp_sel_q.pop_front()});
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tune_word = '0; upd_strobe = 0; prof_strobe = 0;
    auto_zero_arm = 0; zero_hold = 0; op_mode = 2'b00; sine_req = 0;
    mdl_acc = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset phase", phase_word, 32'h0);
    check("R7 reset select", {31'd0, sine_sel}, 32'h0);

    // R1: plain accumulation and modulo wrap
    for (int i = 0; i < 6; i++) drive(32'h1234_5678, 0, 0, 0, 0, 2'b00, 0, "R1 accumulate");
    for (int i = 0; i < 5; i++) drive(32'hC000_0001, 0, 0, 0, 0, 2'b00, 0, "R1 wrap");
    // R3: strobes without arm are ignored
    drive(32'h0100_0000, 1, 0, 0, 0, 2'b00, 0, "R3 unarmed update");
    drive(32'h0100_0000, 0, 1, 0, 0, 2'b00, 0, "R3 unarmed profile");
    drive(32'h0100_0000, 0, 0, 1, 0, 2'b00, 0, "R3 armed idle");
    // R3: armed clears from each strobe
    drive(32'h0100_0000, 1, 0, 1, 0, 2'b00, 0, "R3 armed update");
    drive(32'h0100_0000, 0, 0, 1, 0, 2'b00, 0, "R3 after update");
    drive(32'h0100_0000, 0, 0, 1, 0, 2'b00, 0, "R3 after update");
    drive(32'h0100_0000, 0, 1, 1, 0, 2'b00, 0, "R3 armed profile");
    drive(32'h0100_0000, 0, 0, 1, 0, 2'b00, 0, "R3 after profile");
    // R4: clear event with new word in the same cycle
    drive(32'h0777_0000, 1, 0, 1, 0, 2'b00, 0, "R4 event with new word");
    for (int i = 0; i < 4; i++) drive(32'h0777_0000, 0, 0, 1, 0, 2'b00, 0, "R4 resume");
    // R2: static hold, also over accumulation and events
    for (int i = 0; i < 4; i++) drive(32'h0ABC_0000, 0, 0, 0, 1, 2'b00, 0, "R2 hold");
    drive(32'h0ABC_0000, 1, 1, 1, 1, 2'b00, 0, "R2 hold with event");
    drive(32'h0ABC_0000, 0, 0, 0, 1, 2'b00, 0, "R2 hold");
    for (int i = 0; i < 3; i++) drive(32'h0ABC_0000, 0, 0, 0, 0, 2'b00, 0, "R2 release");
    // R6: select per mode
    drive(32'h0000_0010, 0, 0, 0, 0, 2'b01, 1, "R6 tone sine");
    drive(32'h0000_0010, 0, 0, 0, 0, 2'b01, 0, "R6 tone cosine");
    drive(32'h0000_0010, 0, 0, 0, 0, 2'b00, 1, "R6 quad forces cosine");
    drive(32'h0000_0010, 0, 0, 0, 0, 2'b10, 1, "R6 interp forces cosine");
    drive(32'h0000_0010, 0, 0, 0, 0, 2'b11, 1, "R6 interp forces cosine");
    drive(32'h0000_0010, 0, 0, 0, 0, 2'b01, 1, "R6 tone sine again");
    // R5: latency check on a varying word
    drive(32'hFFFF_FFFF, 0, 0, 0, 0, 2'b00, 0, "R5 lag");
    drive(32'h0000_0003, 0, 0, 0, 0, 2'b00, 0, "R5 lag");
    drive(32'h8000_0000, 0, 0, 0, 0, 2'b00, 0, "R5 lag");
    drive(32'h0000_0000, 0, 0, 0, 0, 2'b00, 0, "R5 lag");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule